// File: doc/BRIEF.md
# Multilevel Space-Vector Offset Locator

This block is the search stage of a three-phase multilevel space-vector modulator. It accepts a normalized reference vector and walks a coordinate origin across the seven-level vector lattice, one lattice step per clock, toward that reference. It stops as soon as the vector left over fits inside the smallest two-level hexagon. What it returns is the level triple of the origin it reached (one integer level per phase), the residual vector measured from that origin, and a one-cycle completion strobe. Later stages turn these into a switching sequence and dwell times using the same arithmetic as a two-level modulator.

Coordinates are signed fixed point with `FRAC_W` fraction bits, where 1.0 is one phase-level step. The first coordinate is alpha. The second, called q, is beta multiplied by 2/√3. In these units the three phase unit vectors are A = (1, 0), B = (−1/2, 1) and C = (−1/2, −1), so every step and every region test is exact. A controller pulses `start_i` with the reference held on the inputs and waits for `done_o`. The results stay on the outputs until the next accepted start.

Top module: `svm_offset_locator`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`, `done_o` and `clip_o` are 0, all three levels are 3, and both residual outputs are 0.
- R2: `start_i` is accepted only while `busy_o` is 0. `busy_o` is 1 from the cycle after acceptance until the search ends. A start pulse seen while busy has no effect on the running search or on its results.
- R3: Each level is an integer from 0 to 6, and 3 is the centre. A search begins at (3,3,3). The offset vector is the sum of (level − 3) times the phase unit vector, with A = (1,0), B = (−1/2,1) and C = (−1/2,−1) in (alpha, q) units.
- R4: Each step moves along whichever of +A, −C, +B, −A, +C, −B (at 0°, 60° … 300°) lies closest in angle to the present residual.
- R5: At completion, the residual outputs equal the accepted reference minus the offset vector, exactly.
- R6: The search stops without a further step once |q| ≤ 1, |2α+q| ≤ 2 and |2α−q| ≤ 2; a point on the hexagon border counts as inside. A reference that already fits takes zero steps. One step is taken per cycle. If start is sampled at edge k and S steps are taken, `done_o` is 1 in the cycle after edge k+S+1. No search takes more than 6 steps.
- R7: `done_o` is a single-cycle pulse. Levels, residual and `clip_o` then hold until the next accepted start.
- R8: A step that would take any level below 0 or above 6 is not applied. The search then ends, with `clip_o` = 1 and the levels and residual left as they were before that step. `clip_o` is cleared by the next accepted start.
- R9: Every step changes exactly one phase level by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search with the present reference |
| ref_alpha_i | input | COORD_W | Reference alpha, signed fixed point |
| ref_q_i | input | COORD_W | Reference beta·2/√3, signed fixed point |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| clip_o | output | 1 | Search ended on a level limit or the step cap |
| lvl_a_o | output | LVL_W | Offset level, phase A |
| lvl_b_o | output | LVL_W | Offset level, phase B |
| lvl_c_o | output | LVL_W | Offset level, phase C |
| res_alpha_o | output | COORD_W | Residual alpha |
| res_q_o | output | COORD_W | Residual q |

## Verification
The bench aims at the hexagon border. A reference sitting exactly on a vertex must take no step, while one LSB beyond it must take exactly one. A fit test that used strict comparisons would add a step, and a loose one would miss one; either error shows up as shifted `done_o` timing and wrong levels. References far along one phase axis drive a level to 6 and then ask for one step more. A design that wrapped the level or still updated the residual would report the wrong triple, or would leave `clip_o` low. Start pulses injected mid-search and in the completion cycle check that a busy engine ignores them and an idle one takes them. Random references in every sector compare the whole walk against a model that picks directions by Euclidean dot product, so a swapped wedge or a wrong unit vector corrupts the final residual.

// File: rtl/svm_offset_pkg.sv
package svm_offset_pkg;

  // bits [2:1]: phase (0=A,1=B,2=C), bit 0: negative direction
  typedef enum logic [2:0] {
    DIR_PA = 3'd0,
    DIR_NA = 3'd1,
    DIR_PB = 3'd2,
    DIR_NB = 3'd3,
    DIR_PC = 3'd4,
    DIR_NC = 3'd5
  } step_dir_e;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walk_state_e;

endpackage

// File: rtl/svm_sector_pick.sv
module svm_sector_pick
  import svm_offset_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic signed [COORD_W-1:0] res_a_i,
  input  logic signed [COORD_W-1:0] res_q_i,
  output step_dir_e                 dir_o
);

  localparam int XW = COORD_W + 3;

  logic signed [XW-1:0] a_x, q_x, three_q, two_a, d_lo, d_hi;
  logic above_lo, above_hi;

  assign a_x     = XW'(res_a_i);
  assign q_x     = XW'(res_q_i);
  assign three_q = (q_x <<< 1) + q_x;
  assign two_a   = a_x <<< 1;
  // wedge borders at 30, 150 (and 210, 330) degrees; 90/270 split by sign of alpha
  assign d_lo    = three_q - two_a;
  assign d_hi    = three_q + two_a;
  assign above_lo = (d_lo >= 0);
  assign above_hi = (d_hi > 0);

  always_comb begin
    case ({above_lo, above_hi})
      2'b01:   dir_o = DIR_PA;
      2'b10:   dir_o = DIR_NA;
      2'b11:   dir_o = (a_x > 0) ? DIR_NC : DIR_PB;
      default: dir_o = (a_x < 0) ? DIR_PC : DIR_NB;
    endcase
  end

endmodule

// File: rtl/svm_hex_fit.sv
module svm_hex_fit #(
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 12
) (
  input  logic signed [COORD_W-1:0] res_a_i,
  input  logic signed [COORD_W-1:0] res_q_i,
  output logic                      fit_o
);

  localparam int XW = COORD_W + 3;
  localparam logic signed [XW-1:0] ONE_X = XW'(1 << FRAC_W);
  localparam logic signed [XW-1:0] TWO_X = XW'(2 << FRAC_W);

  logic signed [XW-1:0] a_x, q_x, e_plus, e_minus;
  logic in_q, in_plus, in_minus;

  assign a_x     = XW'(res_a_i);
  assign q_x     = XW'(res_q_i);
  assign e_plus  = (a_x <<< 1) + q_x;
  assign e_minus = (a_x <<< 1) - q_x;

  // three pairs of parallel edges of the unit hexagon, border inclusive
  assign in_q     = (q_x <= ONE_X) && (q_x >= -ONE_X);
  assign in_plus  = (e_plus <= TWO_X) && (e_plus >= -TWO_X);
  assign in_minus = (e_minus <= TWO_X) && (e_minus >= -TWO_X);
  assign fit_o    = in_q && in_plus && in_minus;

endmodule

// File: rtl/svm_lattice_step.sv
module svm_lattice_step
  import svm_offset_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 12,
  parameter int LEVELS  = 7,
  parameter int LVL_W   = $clog2(LEVELS)
) (
  input  step_dir_e                   dir_i,
  input  logic signed [COORD_W-1:0]   res_a_i,
  input  logic signed [COORD_W-1:0]   res_q_i,
  input  logic [2:0][LVL_W-1:0]       lvl_i,
  output logic signed [COORD_W-1:0]   res_a_o,
  output logic signed [COORD_W-1:0]   res_q_o,
  output logic [2:0][LVL_W-1:0]       lvl_o,
  output logic                        clip_o
);

  localparam logic signed [COORD_W-1:0] ONE  = COORD_W'(1 << FRAC_W);
  localparam logic signed [COORD_W-1:0] HALF = COORD_W'(1 << (FRAC_W - 1));
  localparam logic [LVL_W-1:0]          TOP  = LVL_W'(LEVELS - 1);

  logic [2:0] dir_bits;
  logic [2:0] blk;
  logic signed [COORD_W-1:0] ua, uq;

  assign dir_bits = dir_i;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic hit;
    assign hit = (dir_bits[2:1] == 2'(p));
    assign lvl_o[p] = !hit ? lvl_i[p]
                    : (dir_bits[0] ? lvl_i[p] - LVL_W'(1) : lvl_i[p] + LVL_W'(1));
    assign blk[p] = hit && (dir_bits[0] ? (lvl_i[p] == '0) : (lvl_i[p] >= TOP));
  end

  assign clip_o = |blk;

  always_comb begin
    case (dir_bits[2:1])
      2'd0:    begin ua = ONE;   uq = '0;   end
      2'd1:    begin ua = -HALF; uq = ONE;  end
      2'd2:    begin ua = -HALF; uq = -ONE; end
      default: begin ua = '0;    uq = '0;   end
    endcase
    if (dir_bits[0]) begin
      res_a_o = res_a_i + ua;
      res_q_o = res_q_i + uq;
    end else begin
      res_a_o = res_a_i - ua;
      res_q_o = res_q_i - uq;
    end
  end

endmodule

// File: rtl/svm_offset_locator.sv
module svm_offset_locator
  import svm_offset_pkg::*;
#(
  parameter int LEVELS  = 7,
  parameter int COORD_W = 16,
  parameter int FRAC_W  = 12,
  parameter int LVL_W   = $clog2(LEVELS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [COORD_W-1:0] ref_alpha_i,
  input  logic signed [COORD_W-1:0] ref_q_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      clip_o,
  output logic [LVL_W-1:0]          lvl_a_o,
  output logic [LVL_W-1:0]          lvl_b_o,
  output logic [LVL_W-1:0]          lvl_c_o,
  output logic signed [COORD_W-1:0] res_alpha_o,
  output logic signed [COORD_W-1:0] res_q_o
);

  localparam int MAX_STEPS = LEVELS - 1;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);
  localparam logic [LVL_W-1:0] MID = LVL_W'((LEVELS - 1) / 2);

  walk_state_e               state_q;
  logic signed [COORD_W-1:0] res_a_q, res_q_q, res_a_nxt, res_q_nxt;
  logic [2:0][LVL_W-1:0]     lvl_q, lvl_nxt;
  logic [CNT_W-1:0]          cnt_q;
  logic                      done_q, clip_q;
  step_dir_e                 dir;
  logic                      fit, blk, cap;

  svm_sector_pick #(.COORD_W(COORD_W)) i_sector (
    .res_a_i (res_a_q),
    .res_q_i (res_q_q),
    .dir_o   (dir)
  );

  svm_hex_fit #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) i_fit (
    .res_a_i (res_a_q),
    .res_q_i (res_q_q),
    .fit_o   (fit)
  );

  svm_lattice_step #(
    .COORD_W (COORD_W),
    .FRAC_W  (FRAC_W),
    .LEVELS  (LEVELS),
    .LVL_W   (LVL_W)
  ) i_step (
    .dir_i   (dir),
    .res_a_i (res_a_q),
    .res_q_i (res_q_q),
    .lvl_i   (lvl_q),
    .res_a_o (res_a_nxt),
    .res_q_o (res_q_nxt),
    .lvl_o   (lvl_nxt),
    .clip_o  (blk)
  );

  assign cap = (cnt_q == CNT_W'(MAX_STEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_a_q <= '0;
      res_q_q <= '0;
      lvl_q   <= {3{MID}};
      cnt_q   <= '0;
      done_q  <= 1'b0;
      clip_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WALK;
            res_a_q <= ref_alpha_i;
            res_q_q <= ref_q_i;
            lvl_q   <= {3{MID}};
            cnt_q   <= '0;
            clip_q  <= 1'b0;
          end
        end
        ST_WALK: begin
          if (fit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (cap || blk) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            clip_q  <= 1'b1;
          end else begin
            res_a_q <= res_a_nxt;
            res_q_q <= res_q_nxt;
            lvl_q   <= lvl_nxt;
            cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == ST_WALK);
  assign done_o      = done_q;
  assign clip_o      = clip_q;
  assign lvl_a_o     = lvl_q[0];
  assign lvl_b_o     = lvl_q[1];
  assign lvl_c_o     = lvl_q[2];
  assign res_alpha_o = res_a_q;
  assign res_q_o     = res_q_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R6

  AST_SINGLE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones({lvl_a_o != $past(lvl_a_o), lvl_b_o != $past(lvl_b_o),
                            lvl_c_o != $past(lvl_c_o)}) <= 1)); // R9

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_a_o <= LVL_W'(LEVELS - 1)) && (lvl_b_o <= LVL_W'(LEVELS - 1))
    && (lvl_c_o <= LVL_W'(LEVELS - 1))); // R3

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (cnt_q <= CNT_W'(MAX_STEPS))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(lvl_a_o) && $stable(lvl_b_o) && $stable(lvl_c_o)
                              && $stable(res_alpha_o) && $stable(res_q_o)
                              && $stable(clip_o))); // R7

  AST_CLIP_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clip_o) |-> done_o); // R8

endmodule

// File: tb/test_svm_offset_locator.sv
module test_svm_offset_locator;

  localparam int W    = 16;
  localparam int ONE  = 4096;
  localparam int HALF = 2048;
  localparam int MAXS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0] ref_a = '0, ref_q = '0;
  logic busy_o, done_o, clip_o;
  logic [2:0] lvl_a_o, lvl_b_o, lvl_c_o;
  logic signed [W-1:0] res_alpha_o, res_q_o;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;

  bit m_busy = 1'b0, m_done = 1'b0;
  int m_left = 0;
  int e_l[3];
  int e_ra, e_rq, e_steps;
  bit e_clip;

  always #5 clk = ~clk;

  svm_offset_locator i_svm_offset_locator (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .ref_alpha_i (ref_a),
    .ref_q_i     (ref_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .clip_o      (clip_o),
    .lvl_a_o     (lvl_a_o),
    .lvl_b_o     (lvl_b_o),
    .lvl_c_o     (lvl_c_o),
    .res_alpha_o (res_alpha_o),
    .res_q_o     (res_q_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit fits(int a, int q);
    return (q <= ONE) && (q >= -ONE) && (2*a+q <= 2*ONE) && (2*a+q >= -2*ONE)
        && (2*a-q <= 2*ONE) && (2*a-q >= -2*ONE);
  endfunction

  // directions at k*60 deg: +A, -C, +B, -A, +C, -B
  function automatic void walk(input int a, input int q, output int lv[3],
                               output int ra, output int rq, output int steps,
                               output bit clip, output bit amb);
    real cs[6] = '{1.0, 0.5, -0.5, -1.0, -0.5, 0.5};
    real sn[6] = '{0.0, 0.8660254, 0.8660254, 0.0, -0.8660254, -0.8660254};
    int  ph[6] = '{0, 2, 1, 0, 2, 1};
    int  sg[6] = '{1, -1, 1, -1, 1, -1};
    int  ua[3] = '{ONE, -HALF, -HALF};
    int  uq[3] = '{0, ONE, -ONE};
    bit  stop = 0;
    lv = '{3, 3, 3};
    ra = a; rq = q; steps = 0; clip = 0; amb = 0;
    for (int i = 0; i <= MAXS; i++) begin
      if (!stop) begin
        if (fits(ra, rq)) stop = 1;
        else if (steps == MAXS) begin clip = 1; stop = 1; end
        else begin
          real best = -1.0e9;
          int  bk = 0;
          real beta = rq * 0.8660254;
          if (3*rq == 2*ra || 3*rq == -2*ra || ra == 0) amb = 1;
          for (int k = 0; k < 6; k++) begin
            real d = ra * cs[k] + beta * sn[k];
            if (d > best) begin best = d; bk = k; end
          end
          if (lv[ph[bk]] + sg[bk] < 0 || lv[ph[bk]] + sg[bk] > 6) begin
            clip = 1; stop = 1;
          end else begin
            lv[ph[bk]] += sg[bk];
            ra -= sg[bk] * ua[ph[bk]];
            rq -= sg[bk] * uq[ph[bk]];
            steps++;
          end
        end
      end
    end
  endfunction

  // cycle model of the handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
    end else begin
      bit amb;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          walk(int'(ref_a), int'(ref_q), e_l, e_ra, e_rq, e_steps, e_clip, amb);
          m_busy = 1;
          m_left = e_steps;
        end
      end else if (m_left == 0) begin
        m_busy = 0; m_done = 1;
      end else m_left--;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check("R2 busy", int'(busy_o), int'(m_busy));
      check("R6 R7 done timing", int'(done_o), int'(m_done));
      if (m_done) begin
        check("R3 R4 R9 level A", int'(lvl_a_o), e_l[0]);
        check("R3 R4 R9 level B", int'(lvl_b_o), e_l[1]);
        check("R3 R4 R9 level C", int'(lvl_c_o), e_l[2]);
        check("R5 residual alpha", int'(res_alpha_o), e_ra);
        check("R5 residual q", int'(res_q_o), e_rq);
        check("R8 clip", int'(clip_o), int'(e_clip));
      end
    end
  end

  task automatic run_job(int a, int q);
    @(negedge clk);
    ref_a = W'(a); ref_q = W'(q); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic expect_result(string req, int la, int lb, int lc, int ra, int rq, int cl);
    check({req, " level A"}, int'(lvl_a_o), la);
    check({req, " level B"}, int'(lvl_b_o), lb);
    check({req, " level C"}, int'(lvl_c_o), lc);
    check({req, " residual alpha"}, int'(res_alpha_o), ra);
    check({req, " residual q"}, int'(res_q_o), rq);
    check({req, " clip"}, int'(clip_o), cl);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    expect_result("R1", 3, 3, 3, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_result("R1 after release", 3, 3, 3, 0, 0, 0);
    chk_en = 1'b1;

    // R6 zero steps at origin and on a vertex; one LSB beyond needs one step
    run_job(0, 0);
    expect_result("R6 origin", 3, 3, 3, 0, 0, 0);
    run_job(ONE, 0);
    expect_result("R6 vertex", 3, 3, 3, ONE, 0, 0);
    run_job(ONE + 1, 0);
    expect_result("R4 R9 one step", 4, 3, 3, 1, 0, 0);

    // R8 clip along +A and -A
    run_job(18432, 100);
    expect_result("R8 clip +A", 6, 3, 3, 6144, 100, 1);
    run_job(-18432, -50);
    expect_result("R8 clip -A", 0, 3, 3, -6144, -50, 1);

    // several sectors
    run_job(9011, 10240);
    run_job(-12288, 6963);
    run_job(1638, -12697);
    run_job(-4505, -11059);
    run_job(13517, -12288);

    // R2 start ignored while busy
    @(negedge clk);
    ref_a = W'(14000); ref_q = W'(3000); start = 1'b1;
    @(negedge clk);
    ref_a = W'(-9000); ref_q = W'(-9000);
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    check("R2 ignored start alpha", int'(res_alpha_o), e_ra);

    // R7 outputs hold while idle
    repeat (5) @(negedge clk);
    expect_result("R7 hold", e_l[0], e_l[1], e_l[2], e_ra, e_rq, int'(e_clip));

    // R2 start accepted in the completion cycle
    @(negedge clk);
    ref_a = W'(10000); ref_q = W'(-2000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    ref_a = W'(-7000); ref_q = W'(8000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 back to back busy", int'(busy_o), 1);
    while (m_busy) @(negedge clk);

    // random references, avoiding wedge borders
    for (int n = 0; n < 150; n++) begin
      int a, q, lv[3], ra, rq, st;
      bit cl, amb;
      do begin
        a = int'($urandom_range(0, 45056)) - 22528;
        q = int'($urandom_range(0, 45056)) - 22528;
        walk(a, q, lv, ra, rq, st, cl, amb);
      end while (amb);
      run_job(a, q);
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule